// File: doc/BRIEF.md
# Schedule-Driven Variable Store

This block is the storage element of a time-multiplexed datapath whose operations repeat with a fixed period of T cycles. Intermediate values arrive one per cycle on a single input. Each value must reappear on the single output a fixed number of cycles later. Each stored value is a variable with three elaboration-time properties: a memory cell, a start slot within the period, and a lifetime in cycles. These come from three parameter arrays of equal length.

A wrapping slot counter drives decoders built from that table. In its slot, a variable is written into its cell. A registered read decoder presents the cell on an asynchronous-read RAM one cycle ahead of the output register. A variable with zero lifetime never enters the RAM: it is steered straight into the output register.

An optional input register stage shifts every write, bypass and read by one cycle, which eases timing on wide interleavers. The enable input freezes the whole pipeline without losing the schedule position.

Top module: `sched_var_store`

## Requirements
- R1: While rst is high at a clock edge, the slot counter goes to 0, every pipeline register clears, and dout reads 0 after the edge.
- R2: On each edge with en high, the slot counter advances by one and wraps from T-1 to 0. Every delivery therefore repeats with period T enabled cycles, including lifetimes that cross the period boundary.
- R3: On an edge with en low, no state changes: the counter, input register, decoders, RAM and dout hold, and din is ignored. Counted in enabled cycles, the output sequence is the same as without the stall.
- R4: With IN_SYNC=0, a variable with lifetime L>0 is presented on din in the enabled cycle whose slot equals its start. It is written to its cell and appears on dout L+1 enabled cycles later.
- R5: With IN_SYNC=1, the same variable appears on dout L+2 enabled cycles after it was presented on din.
- R6: A variable with lifetime 0 is routed into the output register without writing the RAM. It appears on dout 1+IN_SYNC enabled cycles after it was presented, and any cell named for it keeps its contents.
- R7: When a read and a write of the same cell fall in the same cycle, the read returns the contents from before that write. A cell can therefore be handed from one variable to the next in the slot where the first is read. This also lets a lifetime of exactly T reuse its own cell.
- R8: In an enabled cycle that loads neither a read result nor a bypass value into the output register, dout keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes the whole block |
| din | input | WL | Value presented in the current schedule slot |
| dout | output | WL | Registered stored or bypassed value |

## Verification
The assertions rely on a consistent table, which the block does not check for itself. No two variables may share a write slot. No two output loads (read or bypass) may fall in the same slot. Live intervals of variables sharing a cell may only touch at the hand-over slot. The bench uses a five-variable table with period 8 that meets these rules while placing a cell hand-over, a full-period lifetime and a bypass into a live cell in the same period. It drives distinct data every cycle through both input-register settings, with stall windows of several lengths in which din keeps changing.

// File: rtl/svs_pkg.sv
package svs_pkg;

  // Which schedule event a decoder instance looks for
  typedef enum logic [1:0] {
    SLOT_WRITE  = 2'd0,
    SLOT_READ   = 2'd1,
    SLOT_BYPASS = 2'd2
  } slot_kind_e;

  // Slot within the period at which the decoder fires for one variable.
  // Read decodes sit one slot early because their output is registered,
  // and the input stage delays both read and bypass by SYNC.
  function automatic int slot_of(slot_kind_e kind, int start, int life,
                                 int sync, int period);
    int raw;
    case (kind)
      SLOT_WRITE: raw = start;
      SLOT_READ:  raw = start + life - 1 + sync;
      default:    raw = start + sync;
    endcase
    return raw % period;
  endfunction

  // Whether a variable takes part in a decoder of the given kind
  function automatic bit slot_used(slot_kind_e kind, int life);
    if (kind == SLOT_BYPASS) return (life == 0);
    return (life != 0);
  endfunction

endpackage

// File: rtl/svs_sched_counter.sv
module svs_sched_counter #(
  parameter int T  = 8,
  parameter int CW = (T > 1) ? $clog2(T) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(T - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/svs_slot_decode.sv
module svs_slot_decode
  import svs_pkg::*;
#(
  parameter int         T     = 8,
  parameter int         CW    = 3,
  parameter int         NV    = 5,
  parameter int         AW    = 2,
  parameter slot_kind_e KIND  = SLOT_WRITE,
  parameter int         SYNC  = 1,
  parameter bit         REG   = 1'b1,
  parameter int         CELL  [NV] = '{default: 0},
  parameter int         START [NV] = '{default: 0},
  parameter int         LIFE  [NV] = '{default: 0}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  output logic          hit,
  output logic [AW-1:0] adr
);

  logic [NV-1:0] hit_v;
  logic [AW-1:0] adr_v [NV];
  logic          hit_c;
  logic [AW-1:0] adr_c;

  // One comparator per table entry that uses this kind of slot
  for (genvar v = 0; v < NV; v++) begin : g_var
    localparam int SLOT = slot_of(KIND, START[v], LIFE[v], SYNC, T);
    if (slot_used(KIND, LIFE[v])) begin : g_on
      assign hit_v[v] = (cnt == CW'(SLOT));
      assign adr_v[v] = hit_v[v] ? AW'(CELL[v]) : '0;
    end else begin : g_off
      assign hit_v[v] = 1'b0;
      assign adr_v[v] = '0;
    end
  end

  // Slots are unique per kind, so an OR merge picks the single match
  always_comb begin
    hit_c = |hit_v;
    adr_c = '0;
    for (int v = 0; v < NV; v++) adr_c = adr_c | adr_v[v];
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        hit <= 1'b0;
        adr <= '0;
      end else if (en) begin
        hit <= hit_c;
        adr <= adr_c;
      end
    end
  end else begin : g_comb
    assign hit = hit_c;
    assign adr = adr_c;
  end

endmodule

// File: rtl/svs_ram.sv
module svs_ram #(
  parameter int WL    = 16,
  parameter int DEPTH = 3,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wadr,
  input  logic [WL-1:0] wdata,
  input  logic [AW-1:0] radr,
  output logic [WL-1:0] rdata
);

  logic [WL-1:0] mem [DEPTH];

  // Write on the edge, read combinationally: a same-cycle read of the
  // written cell sees the contents from before the edge.
  always_ff @(posedge clk) begin
    if (we) mem[wadr] <= wdata;
  end

  assign rdata = mem[radr];

endmodule

// File: rtl/sched_var_store.sv
module sched_var_store
  import svs_pkg::*;
#(
  parameter int WL      = 16,
  parameter int T       = 8,
  parameter int NV      = 5,
  parameter int NCELL   = 3,
  parameter bit IN_SYNC = 1'b1,
  parameter int CELL  [NV] = '{0, 1, 0, 0, 2},
  parameter int START [NV] = '{0, 1, 3, 4, 6},
  parameter int LIFE  [NV] = '{3, 8, 2, 0, 1}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [WL-1:0] din,
  output logic [WL-1:0] dout
);

  localparam int CW   = (T > 1) ? $clog2(T) : 1;
  localparam int AW   = (NCELL > 1) ? $clog2(NCELL) : 1;
  localparam int SYNC = IN_SYNC ? 1 : 0;

  logic [CW-1:0] cnt;
  logic [WL-1:0] wdata;
  logic          wr_en;
  logic [AW-1:0] wr_adr;
  logic          rd_en;
  logic [AW-1:0] rd_adr;
  logic [WL-1:0] rdata;
  logic          byp_hit;

  svs_sched_counter #(.T(T), .CW(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .cnt (cnt)
  );

  // Optional input register; writes and bypass both take its output
  if (IN_SYNC) begin : g_sync
    logic [WL-1:0] din_q;
    always_ff @(posedge clk) begin
      if (rst)     din_q <= '0;
      else if (en) din_q <= din;
    end
    assign wdata = din_q;
  end else begin : g_nosync
    assign wdata = din;
  end

  // Write decode is registered only when the data path is
  svs_slot_decode #(
    .T(T), .CW(CW), .NV(NV), .AW(AW), .KIND(SLOT_WRITE), .SYNC(SYNC),
    .REG(IN_SYNC), .CELL(CELL), .START(START), .LIFE(LIFE)
  ) u_wr_dec (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .cnt (cnt),
    .hit (wr_en),
    .adr (wr_adr)
  );

  // Read decode is always registered and fires one slot early
  svs_slot_decode #(
    .T(T), .CW(CW), .NV(NV), .AW(AW), .KIND(SLOT_READ), .SYNC(SYNC),
    .REG(1'b1), .CELL(CELL), .START(START), .LIFE(LIFE)
  ) u_rd_dec (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .cnt (cnt),
    .hit (rd_en),
    .adr (rd_adr)
  );

  // Bypass slots for zero-lifetime variables (no address needed)
  logic [NV-1:0] byp_v;
  for (genvar v = 0; v < NV; v++) begin : g_byp
    localparam int BSLOT = slot_of(SLOT_BYPASS, START[v], LIFE[v], SYNC, T);
    if (slot_used(SLOT_BYPASS, LIFE[v])) begin : g_on
      assign byp_v[v] = (cnt == CW'(BSLOT));
    end else begin : g_off
      assign byp_v[v] = 1'b0;
    end
  end
  assign byp_hit = |byp_v;

  svs_ram #(.WL(WL), .DEPTH(NCELL), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en & en),
    .wadr  (wr_adr),
    .wdata (wdata),
    .radr  (rd_adr),
    .rdata (rdata)
  );

  // Output register: bypass has priority, otherwise read data, else hold
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (en) begin
      if (byp_hit)    dout <= wdata;
      else if (rd_en) dout <= rdata;
    end
  end

endmodule

// File: rtl/sched_var_store_chk.sv
module sched_var_store_chk #(
  parameter int WL    = 16,
  parameter int T     = 8,
  parameter int NCELL = 3
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                en,
  input logic [WL-1:0]                       dout,
  input logic [((T > 1) ? $clog2(T) : 1)-1:0] cnt,
  input logic                                wr_en,
  input logic [((NCELL > 1) ? $clog2(NCELL) : 1)-1:0] wr_adr,
  input logic                                rd_en,
  input logic                                byp_hit
);

  localparam int CW = (T > 1) ? $clog2(T) : 1;

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == CW'(T - 1)) |=> (cnt == '0));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt != CW'(T - 1)) |=> (cnt == $past(cnt) + CW'(1)));

  // R3
  stall_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));

  // R3
  stall_out_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !rd_en && !byp_hit) |=> $stable(dout));

  // R6
  byp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && byp_hit));

  // R4
  idle_wadr_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_adr == '0));

endmodule

bind sched_var_store sched_var_store_chk #(.WL(WL), .T(T), .NCELL(NCELL)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .dout    (dout),
  .cnt     (cnt),
  .wr_en   (wr_en),
  .wr_adr  (wr_adr),
  .rd_en   (rd_en),
  .byp_hit (byp_hit)
);

// File: tb/sched_var_store_bench.sv
`timescale 1ns/1ps
module sched_var_store_bench;

  localparam int WL   = 16;
  localparam int T    = 8;
  localparam int NV   = 5;
  localparam int NC   = 3;
  localparam int NCYC = 400;
  localparam int B_CELL  [NV] = '{0, 1, 0, 0, 2};
  localparam int B_START [NV] = '{0, 1, 3, 4, 6};
  localparam int B_LIFE  [NV] = '{3, 8, 2, 0, 1};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [WL-1:0] din = '0;
  logic [WL-1:0] dout_s, dout_n;

  always #2.5 clk = ~clk;

  sched_var_store #(
    .WL(WL), .T(T), .NV(NV), .NCELL(NC), .IN_SYNC(1'b1),
    .CELL(B_CELL), .START(B_START), .LIFE(B_LIFE)
  ) u_sched_var_store (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout_s)
  );

  sched_var_store #(
    .WL(WL), .T(T), .NV(NV), .NCELL(NC), .IN_SYNC(1'b0),
    .CELL(B_CELL), .START(B_START), .LIFE(B_LIFE)
  ) u_sched_var_store_nosync (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout_n)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  int k      = 0;                 // enabled-cycle index
  logic [WL-1:0] pres [NCYC];     // value presented in enabled cycle k
  logic [WL-1:0] exp_v [2];       // index 0: no input register, 1: with
  bit            known [2];
  string         tag   [2];

  function automatic string var_tag(int v, int s);
    case (v)
      0:       return "R7";
      1:       return "R2/R7";
      3:       return "R6";
      default: return (s != 0) ? "R5" : "R4";
    endcase
  endfunction

  // Output load for enabled cycle k: variable v lands when k - L - S is
  // a cycle whose slot equals its start (latency L+1+S, output sampled
  // after the edge that ends cycle k).
  task automatic model_step(bit en_v);
    for (int s = 0; s < 2; s++) begin
      tag[s] = en_v ? "R8" : "R3";
      if (en_v) begin
        for (int v = 0; v < NV; v++) begin
          int src;
          src = k - B_LIFE[v] - s;
          if ((((src % T) + T) % T) == B_START[v]) begin
            tag[s] = var_tag(v, s);
            if (src >= 0) begin
              known[s] = 1'b1;
              exp_v[s] = pres[src];
            end else begin
              known[s] = 1'b0;
            end
          end
        end
      end
    end
  endtask

  task automatic check(string req, string what, logic [WL-1:0] act,
                       logic [WL-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state of both configurations
    check("R1", "reset dout sync", dout_s, '0);
    check("R1", "reset dout nosync", dout_n, '0);
    for (int s = 0; s < 2; s++) begin
      known[s] = 1'b1;
      exp_v[s] = '0;
    end

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit            en_v;
      logic [WL-1:0] din_v;
      en_v  = !((cyc >= 50 && cyc < 55) || (cyc >= 123 && cyc < 126) ||
                cyc == 200 || cyc == 301);
      din_v = WL'((cyc * 40503 + 4660) ^ (cyc << 7));
      en    = en_v;
      din   = din_v;   // changes during stalls too (R3: ignored)
      @(posedge clk);
      if (en_v) pres[k] = din_v;
      model_step(en_v);
      if (en_v) k++;
      @(negedge clk);
      if (known[1]) check(tag[1], "dout with input register", dout_s, exp_v[1]);
      if (known[0]) check(tag[0], "dout without input register", dout_n, exp_v[0]);
    end

    done = 1'b1;
    finish_run();
  end

  initial begin
    #((NCYC + 50) * 5 * 2);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

endmodule